// File: doc/BRIEF.md
# Dual-Channel Light Conversion Sequencer

This block sequences an integrating light converter. A modulator outside the block sends one charge-balance pulse per clock at most on `pulse_i`. The block counts these pulses over an integration window. It reports the count as a 16-bit result, together with the final value of the window's cycle counter. It also selects which photodiode channel the front end connects, through `chan_o`, and hands the front end a range code through `range_o`. The range code is held steady for the whole of each window.

The window length comes from one of two sources. In internal timing, a counter of 4, 8, 12 or 16 bits runs through its full span. In external timing, the window is the gap between two sync commands on `sync_i`. Three channel modes are available: channel 1 alone, channel 2 alone, or both channels back to back. In the third mode the second count is subtracted from the first.

Windows run back to back for as long as the mode is non-zero. Each completed result is marked by a single-cycle `done_o`.

Top module: `light_conv_seq`

## Requirements
- R1: `mode_i` encodes 0 = stop, 1 = channel 1 only, 2 = channel 2 only, 3 = difference. `chan_o` is 0 while channel 1 is being integrated and 1 while channel 2 is. In mode 2, `chan_o` is 1 for every window. When the block is idle, `chan_o` is 0.
- R2: In mode 3, a channel-1 window is followed at once by a channel-2 window, and only the end of the channel-2 window raises `done_o`. The result is the channel-1 count minus the channel-2 count.
- R3: In mode 3, when the channel-2 count exceeds the channel-1 count, the result is 0.
- R4: With `ext_time_i` = 0, an idle block with a non-zero mode starts a window at the next edge. `res_i` values 0, 1, 2 and 3 select n = 4, 8, 12 and 16. The window spans 2^n cycles, and pulses in all of them are counted. The timer value reported is 2^n-1.
- R5: With `ext_time_i` = 1, an idle block waits for `sync_i`; a sync cycle starts a window. The window ends on the cycle of the next sync, and that same sync starts the following window. Pulses are counted from the cycle after the starting sync through the ending sync cycle inclusive. The timer value reported is that number of cycles minus one, so two syncs on adjacent cycles give timer 0.
- R6: The result and the timer both saturate at 0xFFFF. They never wrap.
- R7: `result_o` and `timer_o` change only in the cycle where `done_o` is 1. `done_o` rises for one cycle, in the cycle after the last window cycle.
- R8: `range_o` takes the value of `range_i` only at the start of a window. A change of `range_i` during a window leaves `range_o` unchanged until the next window begins.
- R9: Setting `mode_i` to 0 abandons the window in progress at the next edge. No `done_o` follows, and `result_o` and `timer_o` keep their values.
- R10: After reset, `result_o`, `timer_o`, `done_o`, `chan_o` and `range_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode: 0 stop, 1 channel 1, 2 channel 2, 3 difference |
| ext_time_i | input | 1 | 1 selects sync-timed windows, 0 selects the internal counter |
| sync_i | input | 1 | Sync command, one cycle per command |
| res_i | input | 2 | Internal counter width select (4, 8, 12, 16 bits) |
| range_i | input | RANGE_W | Requested range code |
| pulse_i | input | 1 | Charge-balance pulse from the modulator |
| chan_o | output | 1 | Channel select to the front end |
| range_o | output | RANGE_W | Range code in force for the current window |
| result_o | output | DATA_W | Last conversion result |
| timer_o | output | DATA_W | Cycle counter value at the end of the last window |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Saturation is the hardest state to reach. It needs a full 16-bit internal window, or a sync gap longer than 65535 cycles, with a pulse on nearly every cycle. The bench drives one 65536-cycle internal window and one 65600-cycle external window, with the pulse held high throughout. In that case a wrapping counter would read a small value, and the check would catch it. Mode 3 gets its own stimulus: per-window pulse counts are chosen so that both a positive difference and a negative one, which must clamp, follow in one continuous run. Syncs on adjacent cycles exercise the one-cycle external window.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_CH1  = 2'd1,
    MODE_CH2  = 2'd2,
    MODE_DIFF = 2'd3
  } mode_e;

  // last count value of an internal window: 2^(step*(res+1)) - 1
  function automatic logic [31:0] win_limit(input logic [1:0] res, input int unsigned step);
    int unsigned n;
    n = step * (32'(res) + 32'd1);
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << n) - 32'd1;
  endfunction

endpackage

// File: rtl/lcs_win_timer.sv
module lcs_win_timer
  import lcs_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clear_i,
  input  logic              ext_i,
  input  logic [1:0]        res_i,
  input  logic              sync_i,
  output logic              win_end_o,
  output logic [DATA_W-1:0] cyc_o
);

  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] cyc_q;
  logic [DATA_W-1:0] limit;

  assign limit = DATA_W'(win_limit(res_i, RES_STEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (clear_i) begin
      cyc_q <= '0;
    end else if (run_i && (cyc_q != CNT_MAX)) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign win_end_o = run_i && (ext_i ? sync_i : (cyc_q == limit));
  assign cyc_o     = cyc_q;

endmodule

// File: rtl/lcs_pulse_acc.sv
module lcs_pulse_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clear_i,
  input  logic              pulse_i,
  output logic [DATA_W-1:0] sum_o
);

  localparam logic [DATA_W-1:0] ACC_MAX = '1;

  logic [DATA_W-1:0] acc_q;

  // running total including this cycle's pulse, clamped
  assign sum_o = (acc_q == ACC_MAX) ? ACC_MAX : acc_q + DATA_W'(pulse_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
    end else if (run_i) begin
      acc_q <= sum_o;
    end
  end

endmodule

// File: rtl/lcs_seq_ctrl.sv
module lcs_seq_ctrl
  import lcs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RANGE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               ext_i,
  input  logic [1:0]         res_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               sync_i,
  input  logic               win_end_i,
  input  logic [DATA_W-1:0]  sum_i,
  input  logic [DATA_W-1:0]  cyc_i,
  output logic               active_o,
  output logic               clear_o,
  output logic               ext_q_o,
  output logic [1:0]         res_q_o,
  output mode_e              mode_q_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               chan_o,
  output logic [DATA_W-1:0]  result_o,
  output logic [DATA_W-1:0]  timer_o,
  output logic               done_o
);

  mode_e              mode_in, mode_q;
  logic               active_q, phase_q, ext_q, done_q;
  logic [1:0]         res_q;
  logic [RANGE_W-1:0] range_q;
  logic [DATA_W-1:0]  first_q, result_q, timer_q, diff;
  logic               start, abort, end_ok, seq_last;

  assign mode_in  = mode_e'(mode_i);
  assign start    = !active_q && (mode_in != MODE_OFF) && (!ext_i || sync_i);
  assign abort    = active_q && (mode_in == MODE_OFF);
  assign end_ok   = win_end_i && !abort;
  assign seq_last = (mode_q != MODE_DIFF) || phase_q;
  assign diff     = (first_q > sum_i) ? first_q - sum_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_OFF;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      ext_q    <= 1'b0;
      res_q    <= '0;
      range_q  <= '0;
      first_q  <= '0;
      result_q <= '0;
      timer_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      // configuration is sampled once per window, at its start
      if (start || end_ok) begin
        ext_q   <= ext_i;
        res_q   <= res_i;
        range_q <= range_i;
      end
      if (start) begin
        active_q <= 1'b1;
        mode_q   <= mode_in;
        phase_q  <= (mode_in == MODE_CH2);
      end else if (abort) begin
        active_q <= 1'b0;
        phase_q  <= 1'b0;
      end else if (end_ok) begin
        if (!seq_last) begin
          first_q <= sum_i;
          phase_q <= 1'b1;
        end else begin
          result_q <= (mode_q == MODE_DIFF) ? diff : sum_i;
          timer_q  <= cyc_i;
          done_q   <= 1'b1;
          mode_q   <= mode_in;
          phase_q  <= (mode_in == MODE_CH2);
        end
      end
    end
  end

  assign active_o = active_q;
  assign clear_o  = start || end_ok;
  assign ext_q_o  = ext_q;
  assign res_q_o  = res_q;
  assign mode_q_o = mode_q;
  assign range_o  = range_q;
  assign chan_o   = phase_q;
  assign result_o = result_q;
  assign timer_o  = timer_q;
  assign done_o   = done_q;

endmodule

// File: rtl/light_conv_seq.sv
module light_conv_seq
  import lcs_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_STEP = 4,
  parameter int RANGE_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               ext_time_i,
  input  logic               sync_i,
  input  logic [1:0]         res_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               pulse_i,
  output logic               chan_o,
  output logic [RANGE_W-1:0] range_o,
  output logic [DATA_W-1:0]  result_o,
  output logic [DATA_W-1:0]  timer_o,
  output logic               done_o
);

  logic              active, clear, ext_q, win_end;
  logic [1:0]        res_q;
  logic [DATA_W-1:0] sum, cyc;
  mode_e             mode_q;

  lcs_win_timer #(.DATA_W(DATA_W), .RES_STEP(RES_STEP)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active),
    .clear_i   (clear),
    .ext_i     (ext_q),
    .res_i     (res_q),
    .sync_i    (sync_i),
    .win_end_o (win_end),
    .cyc_o     (cyc)
  );

  lcs_pulse_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (active),
    .clear_i (clear),
    .pulse_i (pulse_i),
    .sum_o   (sum)
  );

  lcs_seq_ctrl #(.DATA_W(DATA_W), .RANGE_W(RANGE_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .ext_i     (ext_time_i),
    .res_i     (res_i),
    .range_i   (range_i),
    .sync_i    (sync_i),
    .win_end_i (win_end),
    .sum_i     (sum),
    .cyc_i     (cyc),
    .active_o  (active),
    .clear_o   (clear),
    .ext_q_o   (ext_q),
    .res_q_o   (res_q),
    .mode_q_o  (mode_q),
    .range_o   (range_o),
    .chan_o    (chan_o),
    .result_o  (result_o),
    .timer_o   (timer_o),
    .done_o    (done_o)
  );

endmodule

// File: rtl/lcs_checker.sv
module lcs_checker
  import lcs_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_STEP = 4,
  parameter int RANGE_W  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_i,
  input logic               done_o,
  input logic               chan_o,
  input logic [RANGE_W-1:0] range_o,
  input logic [DATA_W-1:0]  result_o,
  input logic [DATA_W-1:0]  timer_o,
  input logic               win_edge,
  input logic               ext_q,
  input logic [1:0]         res_q,
  input logic [1:0]         mode_q
);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(timer_o)));

  p_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(range_o) |-> $past(win_edge));

  p_timer_int_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(ext_q)) |-> (timer_o == DATA_W'(win_limit($past(res_q), RES_STEP))));

  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'd0) |-> !done_o);

  p_diff_chan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(mode_q) == 2'd3)) |-> $past(chan_o));

endmodule

bind light_conv_seq lcs_checker #(
  .DATA_W(DATA_W), .RES_STEP(RES_STEP), .RANGE_W(RANGE_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .done_o   (done_o),
  .chan_o   (chan_o),
  .range_o  (range_o),
  .result_o (result_o),
  .timer_o  (timer_o),
  .win_edge (clear),
  .ext_q    (ext_q),
  .res_q    (res_q),
  .mode_q   (mode_q)
);

// File: tb/light_conv_seq_bench.sv
module light_conv_seq_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        ext_time_i = 1'b0;
  logic        sync_i = 1'b0;
  logic [1:0]  res_i = 2'd0;
  logic [1:0]  range_i = 2'd0;
  logic        pulse_i = 1'b0;
  logic        chan_o;
  logic [1:0]  range_o;
  logic [15:0] result_o, timer_o;
  logic        done_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  light_conv_seq u_light_conv_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .ext_time_i(ext_time_i),
    .sync_i(sync_i), .res_i(res_i), .range_i(range_i), .pulse_i(pulse_i),
    .chan_o(chan_o), .range_o(range_o), .result_o(result_o), .timer_o(timer_o),
    .done_o(done_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one internal window of w cycles, pulse high on the first np of them
  task automatic run_win(input int w, input int np);
    for (int i = 0; i < w; i++) begin
      pulse_i = (i < np);
      if (i == w / 2 && i > 0) chk("R7 no done mid-window", done_o, 0);
      @(negedge clk_i);
    end
    pulse_i = 1'b0;
  endtask

  // one external window: l cycles after the previous sync, ending sync on the last
  task automatic ext_win(input int l, input int np);
    for (int i = 0; i < l; i++) begin
      pulse_i = (i < np);
      sync_i  = (i == l - 1);
      if (i == l / 2 && i > 0) chk("R7 no done mid-window", done_o, 0);
      @(negedge clk_i);
    end
    sync_i  = 1'b0;
    pulse_i = 1'b0;
  endtask

  task automatic start_int(input logic [1:0] m, input logic [1:0] r, input logic [1:0] rg);
    ext_time_i = 1'b0; mode_i = m; res_i = r; range_i = rg; pulse_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic start_ext(input logic [1:0] m, input logic [1:0] rg);
    ext_time_i = 1'b1; mode_i = m; range_i = rg; sync_i = 1'b1; pulse_i = 1'b0;
    @(negedge clk_i);
    sync_i = 1'b0;
  endtask

  task automatic stop_run();
    mode_i = 2'd0; pulse_i = 1'b0; sync_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic expect_done(input string req, input int res, input int tim);
    chk({req, " done"}, done_o, 1);
    chk({req, " result"}, result_o, res);
    chk({req, " timer"}, timer_o, tim);
  endtask

  task automatic t_reset();
    chk("R10 result", result_o, 0);
    chk("R10 timer", timer_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 chan", chan_o, 0);
    chk("R10 range", range_o, 0);
  endtask

  task automatic t_mode1_int();
    start_int(2'd1, 2'd0, 2'd0);
    chk("R1 mode1 chan", chan_o, 0);
    run_win(16, 16);
    expect_done("R4 n=4", 16, 15);
    run_win(16, 7);
    expect_done("R7 back-to-back", 7, 15);
    stop_run();
  endtask

  task automatic t_mode2_int();
    start_int(2'd2, 2'd1, 2'd0);
    chk("R1 mode2 chan", chan_o, 1);
    run_win(256, 100);
    expect_done("R4 n=8", 100, 255);
    chk("R1 mode2 chan next window", chan_o, 1);
    stop_run();
  endtask

  task automatic t_res12();
    start_int(2'd1, 2'd2, 2'd0);
    run_win(4096, 4096);
    expect_done("R4 n=12", 4096, 4095);
    stop_run();
  endtask

  task automatic t_diff_int();
    start_int(2'd3, 2'd0, 2'd0);
    chk("R2 first channel", chan_o, 0);
    run_win(16, 16);
    chk("R2 no done after ch1", done_o, 0);
    chk("R2 switch to ch2", chan_o, 1);
    run_win(16, 5);
    expect_done("R2 difference", 11, 15);
    chk("R2 back to ch1", chan_o, 0);
    run_win(16, 3);
    run_win(16, 9);
    expect_done("R3 clamp", 0, 15);
    stop_run();
  endtask

  task automatic t_ext();
    start_ext(2'd1, 2'd0);
    ext_win(40, 25);
    expect_done("R5 gap 40", 25, 39);
    ext_win(1, 1);
    expect_done("R5 adjacent syncs", 1, 0);
    ext_win(10, 0);
    expect_done("R5 no pulses", 0, 9);
    stop_run();
    ext_time_i = 1'b1; mode_i = 2'd1;
    for (int i = 0; i < 20; i++) begin
      pulse_i = 1'b1;
      @(negedge clk_i);
      if (done_o) chk("R5 wait for sync", done_o, 0);
    end
    chk("R5 idle without sync", timer_o, 9);
    stop_run();
  endtask

  task automatic t_diff_ext();
    start_ext(2'd3, 2'd0);
    ext_win(20, 15);
    chk("R2 ext no done after ch1", done_o, 0);
    chk("R2 ext ch2 selected", chan_o, 1);
    ext_win(12, 4);
    expect_done("R2 ext difference", 11, 11);
    stop_run();
  endtask

  task automatic t_sat();
    start_int(2'd1, 2'd3, 2'd0);
    run_win(65536, 65536);
    expect_done("R6 internal saturation", 16'hFFFF, 16'hFFFF);
    stop_run();
    start_ext(2'd1, 2'd0);
    ext_win(65600, 65600);
    expect_done("R6 external saturation", 16'hFFFF, 16'hFFFF);
    stop_run();
  endtask

  task automatic t_range();
    start_int(2'd1, 2'd0, 2'd1);
    chk("R8 range at start", range_o, 1);
    for (int i = 0; i < 16; i++) begin
      pulse_i = (i < 2);
      if (i == 3) range_i = 2'd3;
      if (i == 10) chk("R8 range held mid-window", range_o, 1);
      @(negedge clk_i);
    end
    pulse_i = 1'b0;
    expect_done("R8 window", 2, 15);
    chk("R8 range next window", range_o, 3);
    stop_run();
    range_i = 2'd0;
  endtask

  task automatic t_abort();
    int dones;
    dones = 0;
    start_int(2'd1, 2'd0, 2'd0);
    for (int i = 0; i < 6; i++) begin
      pulse_i = 1'b1;
      @(negedge clk_i);
    end
    mode_i = 2'd0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (done_o) dones++;
    end
    pulse_i = 1'b0;
    chk("R9 no done after stop", dones, 0);
    chk("R9 result kept", result_o, 2);
    chk("R9 timer kept", timer_o, 15);
    chk("R1 idle chan", chan_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_mode1_int();
    t_mode2_int();
    t_res12();
    t_diff_int();
    t_ext();
    t_diff_ext();
    t_range();
    t_abort();
    t_sat();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule